// File: doc/BRIEF.md
# Scrambled Rate-1/2 Convolutional Encoder

This block is the bit-level front end of a telemetry frame encoder. It accepts a frame of interleaved block-code bytes (by default 320: 256 data bytes, then 64 parity bytes). It sends each byte out most significant bit first. Every bit is XORed with a pseudo-noise cover that restarts at the start of each frame. The covered bits drive a rate-1/2, constraint-length-7 convolutional encoder, which produces two channel symbols per bit.

After the last byte of a frame, six zero bits are encoded without the cover. These bits return the encoder history to all zeros, so a default frame always yields exactly 5132 symbols. Each symbol is presented with its position in the frame and a flag on the final one. A downstream interleaver places the symbols using that position.

The control is a three-state machine with these states:
- `S_IDLE`: waits for a byte and holds the input ready.
- `S_DATA`: emits the 16 symbols of the accepted byte.
- `S_TAIL`: emits the 12 flush symbols.

The machine takes these transitions:
- `S_IDLE` to `S_DATA` when a byte is accepted.
- `S_DATA` to `S_IDLE` at the end of a byte that is not the last of the frame.
- `S_DATA` to `S_TAIL` at the end of the last byte.
- `S_TAIL` to `S_IDLE` on the last symbol of the frame.

On that last transition the cover generator is reloaded and the encoder history is cleared, ready for the next frame.

Top module: `scr_conv_enc`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `out_last` is 0 and `out_idx` is 0.
- R2: A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until all symbols of that byte have been emitted. A byte presented while `in_ready` is 0 is not taken and does not change the symbol stream.
- R3: Each byte is encoded bit 7 first. Each bit is XORed with the cover bit of the same position in the frame. The cover follows a(n+8) = a(n+7) ^ a(n+5) ^ a(n+3) ^ a(n), which is polynomial x^8+x^7+x^5+x^3+1. Its first eight bits are 1. It runs without restart across all data and parity bytes of the frame, so bit 8k+j of the frame uses cover bit 8k+j.
- R4: For each covered bit b, with d1..d6 the previously encoded bits of the frame (d1 the most recent, zero at frame start), two symbols are emitted in this order: b^d1^d2^d3^d6 (generator 171 octal), then the inverse of b^d2^d3^d5^d6 (generator 133 octal). In each generator, bit 6 taps b and bit 0 taps d6.
- R5: After the last byte of a frame, six zero bits that bypass the cover are encoded by the R4 rule. They follow the last byte's symbols without a gap and give 12 symbols.
- R6: A frame gives (8*NBYTES+6)*2 symbols (5132 by default). `out_idx` counts them from 0 and rises by one on each valid symbol.
- R7: `out_last` is 1 only on the symbol with index (8*NBYTES+6)*2-1. On the next cycle `out_idx` is 0, and the next frame starts with a fresh cover and a cleared history.
- R8: After a byte is taken, `out_valid` is 1 for 16 consecutive cycles, or 28 for the last byte of a frame. Between a byte and the next one taken, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_valid | output | 1 | A symbol is present |
| out_sym | output | 1 | Channel symbol |
| out_idx | output | 13 | Position of the symbol in the frame |
| out_last | output | 1 | Final symbol of the frame |

## Verification
The bench builds the block with its default parameters: 320 bytes per frame, six tail bits and the 171/133 generators. With these values the 2560 covered bits pass the cover period of 255 about ten times, and the index reaches 5131, its full 13-bit width at that frame length. Three back-to-back frames test the frame boundary: the cover reload, the history clear and the index wrap.

The three frames use different data:
- all zeros, with idle gaps between bytes;
- a ramp, with bytes offered while the block is busy;
- bytes equal to the cover, so every covered bit is zero.

// File: rtl/scr_conv_pkg.sv
package scr_conv_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_TAIL = 2'd2
    } enc_state_e;

endpackage

// File: rtl/scr_pn_lfsr.sv
module scr_pn_lfsr #(
    parameter int          LEN     = 8,
    parameter logic [LEN-1:0] FB_MASK = 8'h95,
    parameter logic [LEN-1:0] SEED    = '1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic step,
    output logic pn_bit
);

    logic [LEN-1:0] reg_q;

    // Fibonacci form: the oldest bit is output, the new bit is shifted in at bit 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= SEED;
        end else if (reload) begin
            reg_q <= SEED;
        end else if (step) begin
            reg_q <= {reg_q[LEN-2:0], ^(reg_q & FB_MASK)};
        end
    end

    assign pn_bit = reg_q[LEN-1];

endmodule

// File: rtl/scr_conv_core.sv
module scr_conv_core #(
    parameter int            K   = 7,
    parameter logic [K-1:0]  G_A = 7'o171,
    parameter logic [K-1:0]  G_B = 7'o133
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic phase,
    input  logic bit_i,
    output logic sym_o
);

    localparam int MEM = K - 1;

    logic [MEM-1:0] hist_q;
    logic [K-1:0]   window;
    logic [1:0]     gsym;

    // bit K-1 of the window is the current bit, bit 0 the oldest one
    assign window = {bit_i, hist_q};

    for (genvar g = 0; g < 2; g++) begin : g_branch
        localparam logic [K-1:0] TAP = (g == 0) ? G_A : G_B;
        assign gsym[g] = ^(window & TAP);
    end

    assign sym_o = phase ? ~gsym[1] : gsym[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (advance) begin
            hist_q <= window[K-1:1];
        end
    end

endmodule

// File: rtl/scr_sym_index.sv
module scr_sym_index #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (inc) begin
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/scr_conv_enc.sv
module scr_conv_enc
    import scr_conv_pkg::*;
#(
    parameter int               NBYTES    = 320,
    parameter int               TAIL_BITS = 6,
    parameter int               K         = 7,
    parameter logic [K-1:0]     G_A       = 7'o171,
    parameter logic [K-1:0]     G_B       = 7'o133,
    parameter int               PN_LEN    = 8,
    parameter logic [PN_LEN-1:0] PN_MASK  = 8'h95,
    localparam int              NSYM      = (NBYTES * 8 + TAIL_BITS) * 2,
    localparam int              IDXW      = $clog2(NSYM)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_data,
    output logic            in_ready,
    output logic            out_valid,
    output logic            out_sym,
    output logic [IDXW-1:0] out_idx,
    output logic            out_last
);

    localparam int BCW = (NBYTES > 2) ? $clog2(NBYTES) : 1;
    localparam int CW  = (TAIL_BITS > 8) ? $clog2(TAIL_BITS) : 3;

    enc_state_e       state_q, state_d;
    logic [7:0]       sreg_q;
    logic [CW-1:0]    bit_q;
    logic             ph_q;
    logic [BCW-1:0]   byte_q;

    logic             accept;
    logic             byte_end;
    logic             tail_end;
    logic             last_byte;
    logic             pn_bit;
    logic             cur_bit;

    assign accept    = (state_q == S_IDLE) && in_valid;
    assign byte_end  = (state_q == S_DATA) && ph_q && (bit_q == CW'(7));
    assign tail_end  = (state_q == S_TAIL) && ph_q && (bit_q == CW'(TAIL_BITS - 1));
    assign last_byte = (byte_q == BCW'(NBYTES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (in_valid) state_d = S_DATA;
            S_DATA:  if (byte_end) state_d = last_byte ? S_TAIL : S_IDLE;
            S_TAIL:  if (tail_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // serializer, bit/phase and byte counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            bit_q  <= '0;
            ph_q   <= 1'b0;
            byte_q <= '0;
        end else if (accept) begin
            sreg_q <= in_data;
            bit_q  <= '0;
            ph_q   <= 1'b0;
        end else if (state_q != S_IDLE) begin
            ph_q <= ~ph_q;
            if (ph_q) begin
                bit_q <= (byte_end || tail_end) ? '0 : bit_q + 1'b1;
                if (state_q == S_DATA) sreg_q <= {sreg_q[6:0], 1'b0};
            end
            if (byte_end) byte_q <= last_byte ? '0 : byte_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == S_IDLE);
        out_valid = (state_q != S_IDLE);
        out_last  = tail_end;
        cur_bit   = (state_q == S_DATA) ? (sreg_q[7] ^ pn_bit) : 1'b0;
    end

    scr_pn_lfsr #(
        .LEN     (PN_LEN),
        .FB_MASK (PN_MASK),
        .SEED    ({PN_LEN{1'b1}})
    ) u_pn (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (tail_end),
        .step   ((state_q == S_DATA) && ph_q),
        .pn_bit (pn_bit)
    );

    scr_conv_core #(
        .K   (K),
        .G_A (G_A),
        .G_B (G_B)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tail_end),
        .advance (out_valid && ph_q),
        .phase   (ph_q),
        .bit_i   (cur_bit),
        .sym_o   (out_sym)
    );

    scr_sym_index #(
        .W (IDXW)
    ) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tail_end),
        .inc   (out_valid),
        .idx   (out_idx)
    );

endmodule

// File: rtl/scr_conv_enc_chk.sv
module scr_conv_enc_chk #(
    parameter int NSYM = 5132,
    parameter int IDXW = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic [IDXW-1:0] out_idx,
    input logic            out_last
);

    // R2: the block never takes input while it is emitting symbols
    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R8: a taken byte starts a busy stretch on the next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && !in_ready));

    // R6: index steps by one between consecutive symbols of a frame
    a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (!out_valid || (out_idx == $past(out_idx) + 1'b1)));

    // R6: index holds while no symbol is emitted
    a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !in_valid) |=> $stable(out_idx));

    // R7: final flag only on the last index of a frame
    a_r7_last_idx: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_valid && (out_idx == IDXW'(NSYM - 1))));

    // R7: index wraps to zero after the final symbol
    a_r7_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> (out_idx == '0));

endmodule

bind scr_conv_enc scr_conv_enc_chk #(
    .NSYM (NSYM),
    .IDXW (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_last  (out_last)
);

// File: tb/scr_conv_enc_test.sv
`timescale 1ns/1ps
module scr_conv_enc_test;

    localparam int NBYTES = 320;
    localparam int TAILN  = 6;
    localparam int NSYM   = (NBYTES * 8 + TAILN) * 2;
    localparam int IDXW   = $clog2(NSYM);
    localparam int NFRAMES = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      in_data = 8'h00;
    logic            in_ready;
    logic            out_valid;
    logic            out_sym;
    logic [IDXW-1:0] out_idx;
    logic            out_last;

    always #4 clk = ~clk;

    scr_conv_enc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sym   (out_sym),
        .out_idx   (out_idx),
        .out_last  (out_last)
    );

    typedef struct packed {
        logic        sym;
        logic [12:0] idx;
        logic        last;
        logic        tail;
    } exp_item_t;

    exp_item_t exp_q[$];

    int  checks = 0;
    int  errors = 0;
    bit  pn [0:NBYTES*8-1];
    bit  h1, h2, h3, h4, h5, h6;
    int  model_idx;
    int  pn_pos;
    int  frames_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // model of R4: one covered bit becomes two expected symbols
    task automatic push_bit(input bit b, input bit tail);
        exp_item_t e;
        bit s1, s2;
        s1 = b ^ h1 ^ h2 ^ h3 ^ h6;
        s2 = ~(b ^ h2 ^ h3 ^ h5 ^ h6);
        e.sym = s1; e.idx = 13'(model_idx); e.last = (model_idx == NSYM - 1); e.tail = tail;
        exp_q.push_back(e);
        model_idx++;
        e.sym = s2; e.idx = 13'(model_idx); e.last = (model_idx == NSYM - 1); e.tail = tail;
        exp_q.push_back(e);
        model_idx++;
        h6 = h5; h5 = h4; h4 = h3; h3 = h2; h2 = h1; h1 = b;
    endtask

    // driver; always entered and left at a falling edge
    task automatic send_byte(input logic [7:0] d, input bit garbage);
        if (garbage && !in_ready) begin
            in_valid = 1'b1;
            in_data  = ~d;
        end
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        for (int i = 7; i >= 0; i--) begin
            push_bit(d[i] ^ pn[pn_pos], 1'b0);   // R3 cover
            pn_pos++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R2 ready low after accept", int'(in_ready), 0);
    endtask

    // monitor / scoreboard
    int run_len = 0;
    int frame_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                run_len++;
                frame_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected symbol", int'(out_idx), -1);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    chk(out_sym == e.sym, e.tail ? "R5 tail symbol" : "R3 R4 symbol",
                        int'(out_sym), int'(e.sym));
                    chk(out_idx == e.idx[IDXW-1:0], "R6 index", int'(out_idx), int'(e.idx));
                    chk(out_last == e.last, "R7 last flag", int'(out_last), int'(e.last));
                end
                if (out_last) begin
                    chk(frame_cnt == NSYM, "R6 symbols per frame", frame_cnt, NSYM);
                    frame_cnt = 0;
                    frames_seen++;
                end
            end else if (run_len > 0) begin
                chk(run_len == 16 || run_len == 16 + 2 * TAILN, "R8 burst length", run_len, 16);
                run_len = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R3 cover sequence by its recurrence, seeded with eight ones
        for (int n = 0; n < NBYTES * 8; n++) begin
            if (n < 8) pn[n] = 1'b1;
            else       pn[n] = pn[n-1] ^ pn[n-3] ^ pn[n-5] ^ pn[n-8];
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1 reset out_last", int'(out_last), 0);
        chk(out_idx == '0, "R1 reset out_idx", int'(out_idx), 0);

        for (int f = 0; f < NFRAMES; f++) begin
            h1 = 0; h2 = 0; h3 = 0; h4 = 0; h5 = 0; h6 = 0;
            model_idx = 0;
            pn_pos = 0;
            for (int k = 0; k < NBYTES; k++) begin
                logic [7:0] d;
                bit garb;
                garb = 1'b0;
                case (f)
                    0: d = 8'h00;
                    1: begin d = 8'(k * 7 + 3); garb = (k % 5 == 0); end
                    default: d = {pn[8*k], pn[8*k+1], pn[8*k+2], pn[8*k+3],
                                  pn[8*k+4], pn[8*k+5], pn[8*k+6], pn[8*k+7]};
                endcase
                if (f == 0) begin
                    while (!in_ready) @(negedge clk);
                    repeat (k % 3) @(negedge clk);
                end
                send_byte(d, garb);
            end
            for (int t = 0; t < TAILN; t++) push_bit(1'b0, 1'b1);  // R5
        end

        while (exp_q.size() != 0 || out_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected symbols seen", exp_q.size(), 0);
        chk(frames_seen == NFRAMES, "R7 frame ends seen", frames_seen, NFRAMES);
        chk(in_ready == 1'b1 && out_idx == '0, "R7 idle after last frame", int'(out_idx), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule